// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of stereo PCM samples into a consumer digital-audio line signal. It runs on a symbol clock at 128 times the sample rate, and each clock cycle is one half-cell on the line. A frame holds two subframes of 32 time slots each. Every subframe opens with a four-slot synchronisation preamble. The 24-bit sample follows, least significant bit first. Last come a validity flag, one user bit, one channel-status bit and an even-parity bit. All slots after the preamble are biphase-mark coded.

Samples arrive one stereo pair per frame over a ready/valid port, and the block pulls each pair at the first half-cell of its frame. If no pair is waiting at that point, a null frame goes out and an underrun pulse is raised; the transmitter never stalls. Two 192-bit banks (channel status and user data) are written one 32-bit word at a time into a shadow copy. The shadow becomes live at the next block boundary. Frame n of a block carries bit n of each bank. A block-end pulse and one reload pulse per bank tell the control side when a new block has started.

Top module: `spdif_tx`

## Requirements
- R1: While `tx_en_i` is low, `tx_o`, `smp_ready_o`, `udr_o`, `blk_end_o`, `cs_rdy_o` and `ud_rdy_o` stay low. Raising `tx_en_i` starts at frame 0 of a block, with the line level taken as low before the first half-cell.
- R2: A frame lasts 128 clock cycles, one half-cell per cycle. `smp_ready_o` is high in the first cycle of every frame and in no other cycle. `tx_o` shows half-cell p of the frame one cycle after the cycle in which p is scheduled.
- R3: In every slot from 4 to 31, `tx_o` inverts at the start of the slot, and inverts again at mid-slot when the slot's bit is 1.
- R4: Slots 0 to 3 carry a preamble of eight half-cells. With a low level before it, the left subframe of frame 0 sends 11101000, the left subframe of any other frame sends 11100010, and the right subframe sends 11100100. All of these are inverted when the level before the preamble is high.
- R5: Slots 4 to 27 carry the sample, least significant bit first. Slot 28 carries V, slot 29 the user bit, slot 30 the channel-status bit, and slot 31 parity that makes the count of ones over slots 4 to 31 even.
- R6: When `mono_i` is high, the left sample is sent in both subframes of the frame.
- R7: The V slot of the left subframe carries `vld_a_i`, and the V slot of the right subframe carries `vld_b_i`.
- R8: If `smp_valid_i` is low in the first cycle of a frame, `udr_o` pulses in that cycle. Both subframes then carry a zero sample, and their V slot is the inverse of `null_vld_i`: 0 selects flagged invalid (V=1), 1 selects flagged valid (V=0).
- R9: Frame n (0 to 191) of a block sends bit n of the live channel-status bank and bit n of the live user bank in both subframes. Bit n sits in word n/32 at bit n%32.
- R10: A word written while the transmitter runs takes effect at the first frame of the next block. A word written while `tx_en_i` is low is live from the next enable.
- R11: `blk_end_o` pulses in the last cycle of frame 191 and in no other cycle.
- R12: `cs_rdy_o` and `ud_rdy_o` pulse together with `blk_end_o` only if their bank was written since the last boundary or since enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock, 128 x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| mono_i | input | 1 | Send left sample on both subframes |
| vld_a_i | input | 1 | V flag for the left subframe |
| vld_b_i | input | 1 | V flag for the right subframe |
| null_vld_i | input | 1 | Null frame flagging: 0 invalid, 1 valid |
| smp_valid_i | input | 1 | Stereo pair available |
| smp_ready_o | output | 1 | Pair taken this cycle |
| smp_left_i | input | 24 | Left sample |
| smp_right_i | input | 24 | Right sample |
| cs_we_i | input | 1 | Channel-status word write |
| cs_widx_i | input | 3 | Channel-status word index |
| cs_wdata_i | input | 32 | Channel-status word data |
| ud_we_i | input | 1 | User word write |
| ud_widx_i | input | 3 | User word index |
| ud_wdata_i | input | 32 | User word data |
| tx_o | output | 1 | Biphase-mark line output |
| blk_end_o | output | 1 | Last cycle of the block |
| cs_rdy_o | output | 1 | Channel-status shadow committed |
| ud_rdy_o | output | 1 | User shadow committed |
| udr_o | output | 1 | Sample underrun, null frame sent |

## Verification
The assertions assume that `tx_en_i` changes only between frames or while idle. They also assume that bank writes use word indices below six, and that the mode inputs stay stable for the whole frame in which they are used. The stimulus changes mode and sample inputs only in the cycle in which a frame is fetched. It writes banks either while idle or at a fixed point inside a frame, and it disables the transmitter only after a frame has completed.

// File: rtl/spdif_tx_pkg.sv
`timescale 1ns/1ps
package spdif_tx_pkg;
  localparam int AUD_W     = 24;
  localparam int SLOTS     = 32;
  localparam int PRE_SLOTS = 4;
  localparam int HC_FRAME  = 4 * SLOTS;
  localparam int POS_W     = $clog2(HC_FRAME);
  localparam int FIELD_W   = SLOTS - PRE_SLOTS;

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_e;

  // half-cell patterns, first half-cell in bit 7, for a low level before the preamble
  function automatic logic [7:0] pre_pattern(input pre_e sel);
    logic [7:0] pat;
    unique case (sel)
      PRE_B:   pat = 8'b1110_1000;
      PRE_M:   pat = 8'b1110_0010;
      default: pat = 8'b1110_0100;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/spdif_tx_bank.sv
`timescale 1ns/1ps
module spdif_tx_bank #(
  parameter  int FRAMES = 192,
  parameter  int WORD_W = 32,
  localparam int NWORDS = FRAMES / WORD_W,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int SEL_W  = $clog2(FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              bit_o,
  output logic              rdy_o
);
  logic [NWORDS-1:0][WORD_W-1:0] shadow_q;
  logic [FRAMES-1:0]             active_q;
  logic                          dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      if (load_i || commit_i) begin
        active_q <= shadow_q;
        dirty_q  <= 1'b0;
      end
      if (we_i && (int'(widx_i) < NWORDS)) begin
        shadow_q[widx_i] <= wdata_i;
        dirty_q          <= 1'b1;
      end
    end
  end

  assign bit_o = active_q[sel_i];
  assign rdy_o = commit_i && dirty_q;

  // R12
  rdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && !we_i |=> !dirty_q);
  // R10
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !commit_i |=> $stable(active_q));
endmodule

// File: rtl/spdif_tx_seq.sv
`timescale 1ns/1ps
module spdif_tx_seq
  import spdif_tx_pkg::*;
#(
  parameter  int FRAMES = 192,
  localparam int FR_W   = $clog2(FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smp_valid_i,
  input  logic [AUD_W-1:0] smp_left_i,
  input  logic [AUD_W-1:0] smp_right_i,
  output logic             smp_ready_o,
  output logic             udr_o,
  output logic [POS_W-1:0] pos_o,
  output logic [FR_W-1:0]  frame_o,
  output logic [AUD_W-1:0] left_o,
  output logic [AUD_W-1:0] right_o,
  output logic             null_o,
  output logic             blk_end_o,
  output logic             commit_o,
  output logic             load_o
);
  logic [POS_W-1:0] pos_q;
  logic [FR_W-1:0]  frame_q;
  logic             frame_start, frame_last, block_last;

  assign frame_start = en_i && (pos_q == '0);
  assign frame_last  = en_i && (pos_q == POS_W'(HC_FRAME - 1));
  assign block_last  = frame_last && (frame_q == FR_W'(FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else if (!en_i) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else begin
      pos_q <= pos_q + POS_W'(1);
      if (frame_last) frame_q <= block_last ? '0 : frame_q + FR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      null_o  <= 1'b0;
    end else if (frame_start) begin
      if (smp_valid_i) begin
        left_o  <= smp_left_i;
        right_o <= smp_right_i;
        null_o  <= 1'b0;
      end else begin
        left_o  <= '0;
        right_o <= '0;
        null_o  <= 1'b1;
      end
    end
  end

  assign smp_ready_o = frame_start;
  assign udr_o       = frame_start && !smp_valid_i;
  assign blk_end_o   = block_last;
  assign commit_o    = block_last;
  assign load_o      = !en_i;
  assign pos_o       = pos_q;
  assign frame_o     = frame_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !smp_ready_o && !udr_o && !blk_end_o);
  // R2
  fetch_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |=> pos_o == POS_W'(1));
  // R8
  udr_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udr_o |=> null_o && left_o == '0 && right_o == '0);
  // R11
  blk_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_o && en_i |=> frame_o == '0 && pos_o == '0);
endmodule

// File: rtl/spdif_tx_bmc.sv
`timescale 1ns/1ps
module spdif_tx_bmc
  import spdif_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             first_frame_i,
  input  logic [AUD_W-1:0] left_i,
  input  logic [AUD_W-1:0] right_i,
  input  logic             null_i,
  input  logic             mono_i,
  input  logic             vld_a_i,
  input  logic             vld_b_i,
  input  logic             null_vld_i,
  input  logic             cs_bit_i,
  input  logic             ud_bit_i,
  output logic             tx_o
);
  logic               sub, half, in_pre;
  logic [4:0]         slot, didx;
  logic [2:0]         pidx;
  logic [AUD_W-1:0]   aud;
  logic               v_bit, par, dbit, pbit, ref_now, nxt;
  logic [FIELD_W-2:0] body;
  logic [FIELD_W-1:0] field;
  logic [7:0]         pat;
  pre_e               pre_sel;
  logic               tx_q, ref_q;

  assign sub    = pos_i[POS_W-1];
  assign slot   = pos_i[POS_W-2:1];
  assign half   = pos_i[0];
  assign in_pre = slot < 5'(PRE_SLOTS);
  assign pidx   = {slot[1:0], half};
  assign didx   = slot - 5'(PRE_SLOTS);

  always_comb begin
    aud     = (!sub || mono_i) ? left_i : right_i;
    v_bit   = null_i ? !null_vld_i : (sub ? vld_b_i : vld_a_i);
    body    = {cs_bit_i, ud_bit_i, v_bit, aud};
    par     = ^body;
    field   = {par, body};
    dbit    = field[didx];
    pre_sel = sub ? PRE_W : (first_frame_i ? PRE_B : PRE_M);
    pat     = pre_pattern(pre_sel);
    pbit    = pat[3'd7 - pidx];
    ref_now = (pidx == 3'd0) ? tx_q : ref_q;
    if (in_pre)     nxt = pbit ^ ref_now;
    else if (!half) nxt = !tx_q;
    else            nxt = dbit ? !tx_q : tx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      ref_q <= 1'b0;
    end else if (!en_i) begin
      tx_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      tx_q <= nxt;
      if (in_pre && pidx == 3'd0) ref_q <= tx_q;
    end
  end

  assign tx_o = tx_q;

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tx_o);
  // R3
  cell_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !in_pre && !half |=> tx_o != $past(tx_o));
endmodule

// File: rtl/spdif_tx.sv
`timescale 1ns/1ps
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter  int FRAMES = 192,
  parameter  int WORD_W = 32,
  localparam int NWORDS = FRAMES / WORD_W,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int FR_W   = $clog2(FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              mono_i,
  input  logic              vld_a_i,
  input  logic              vld_b_i,
  input  logic              null_vld_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [AUD_W-1:0]  smp_left_i,
  input  logic [AUD_W-1:0]  smp_right_i,
  input  logic              cs_we_i,
  input  logic [IDX_W-1:0]  cs_widx_i,
  input  logic [WORD_W-1:0] cs_wdata_i,
  input  logic              ud_we_i,
  input  logic [IDX_W-1:0]  ud_widx_i,
  input  logic [WORD_W-1:0] ud_wdata_i,
  output logic              tx_o,
  output logic              blk_end_o,
  output logic              cs_rdy_o,
  output logic              ud_rdy_o,
  output logic              udr_o
);
  logic [POS_W-1:0] pos;
  logic [FR_W-1:0]  frame;
  logic [AUD_W-1:0] left, right;
  logic             null_f, commit, load, cs_bit, ud_bit;

  spdif_tx_seq #(.FRAMES(FRAMES)) i_seq (
    .clk_i, .rst_ni,
    .en_i        (tx_en_i),
    .smp_valid_i,
    .smp_left_i,
    .smp_right_i,
    .smp_ready_o,
    .udr_o,
    .pos_o       (pos),
    .frame_o     (frame),
    .left_o      (left),
    .right_o     (right),
    .null_o      (null_f),
    .blk_end_o,
    .commit_o    (commit),
    .load_o      (load)
  );

  spdif_tx_bank #(.FRAMES(FRAMES), .WORD_W(WORD_W)) i_cs_bank (
    .clk_i, .rst_ni,
    .we_i     (cs_we_i),
    .widx_i   (cs_widx_i),
    .wdata_i  (cs_wdata_i),
    .load_i   (load),
    .commit_i (commit),
    .sel_i    (frame),
    .bit_o    (cs_bit),
    .rdy_o    (cs_rdy_o)
  );

  spdif_tx_bank #(.FRAMES(FRAMES), .WORD_W(WORD_W)) i_ud_bank (
    .clk_i, .rst_ni,
    .we_i     (ud_we_i),
    .widx_i   (ud_widx_i),
    .wdata_i  (ud_wdata_i),
    .load_i   (load),
    .commit_i (commit),
    .sel_i    (frame),
    .bit_o    (ud_bit),
    .rdy_o    (ud_rdy_o)
  );

  spdif_tx_bmc i_bmc (
    .clk_i, .rst_ni,
    .en_i          (tx_en_i),
    .pos_i         (pos),
    .first_frame_i (frame == '0),
    .left_i        (left),
    .right_i       (right),
    .null_i        (null_f),
    .mono_i,
    .vld_a_i,
    .vld_b_i,
    .null_vld_i,
    .cs_bit_i      (cs_bit),
    .ud_bit_i      (ud_bit),
    .tx_o
  );

  // R12
  rdy_with_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rdy_o || ud_rdy_o) |-> blk_end_o);
endmodule

// File: tb/test_spdif_tx.sv
`timescale 1ns/1ps
module test_spdif_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_en_i = 1'b0, mono_i = 1'b0, vld_a_i = 1'b0, vld_b_i = 1'b0, null_vld_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [23:0] smp_left_i = '0, smp_right_i = '0;
  logic        cs_we_i = 1'b0, ud_we_i = 1'b0;
  logic [2:0]  cs_widx_i = '0, ud_widx_i = '0;
  logic [31:0] cs_wdata_i = '0, ud_wdata_i = '0;
  logic        tx_o, blk_end_o, cs_rdy_o, ud_rdy_o, udr_o;

  spdif_tx i_spdif_tx (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [31:0]  cs_act [6];
  logic [31:0]  ud_act [6];
  logic         model_lvl = 1'b0;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  bit           mon_on = 1'b0;
  bit           pend_wr = 1'b0;
  logic [31:0]  pend_data = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] frame_exp(input int f, input logic [23:0] l, input logic [23:0] r,
                                             input bit have, input bit mono, input bit va, input bit vb, input bit nv);
    logic [127:0] v = '0;
    int p = 0;
    for (int s = 0; s < 2; s++) begin
      logic [23:0] aud;
      logic        vbit, cbit, ubit, start;
      logic [7:0]  pat;
      logic [27:0] bits;
      aud  = !have ? 24'h0 : ((s == 0 || mono) ? l : r);
      vbit = !have ? !nv : (s == 0 ? va : vb);
      cbit = cs_act[f / 32][f % 32];
      ubit = ud_act[f / 32][f % 32];
      pat  = (s == 1) ? 8'b11100100 : ((f == 0) ? 8'b11101000 : 8'b11100010);
      start = model_lvl;
      for (int i = 0; i < 8; i++) begin
        v[p] = pat[7 - i] ^ start;
        model_lvl = v[p];
        p++;
      end
      bits = {^{cbit, ubit, vbit, aud}, cbit, ubit, vbit, aud};
      for (int k = 0; k < 28; k++) begin
        model_lvl = ~model_lvl;
        v[p] = model_lvl; p++;
        if (bits[k]) model_lvl = ~model_lvl;
        v[p] = model_lvl; p++;
      end
    end
    return v;
  endfunction

  // driver: entered just after a negedge, returns just after the negedge ending the frame
  task automatic drive_frame(input int f, input logic [23:0] l, input logic [23:0] r, input bit have,
                             input bit mono, input bit va, input bit vb, input bit nv, input string tag,
                             input bit exp_cs_rdy, input bit exp_ud_rdy);
    mono_i = mono; vld_a_i = va; vld_b_i = vb; null_vld_i = nv;
    smp_left_i = l; smp_right_i = r; smp_valid_i = have;
    exp_q.push_back(frame_exp(f, l, r, have, mono, va, vb, nv));
    tag_q.push_back(tag);
    #1;
    mon_on = 1'b1;
    chk(smp_ready_o === 1'b1 && udr_o === !have, "R2 R8 fetch", {smp_ready_o, udr_o}, {1'b1, !have});
    for (int k = 1; k <= 128; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        smp_valid_i = 1'b0;
        chk(smp_ready_o === 1'b0, "R2 ready mid-frame", smp_ready_o, 0);
      end
      if (k == 10 && pend_wr) begin
        cs_we_i = 1'b1; cs_widx_i = 3'd0; cs_wdata_i = pend_data;
      end
      if (k == 11) cs_we_i = 1'b0;
      if (k == 127) begin
        if (f == 191) begin
          chk(blk_end_o === 1'b1, "R11 block end", blk_end_o, 1);
          chk(cs_rdy_o === exp_cs_rdy && ud_rdy_o === exp_ud_rdy, "R12 reload pulses",
              {cs_rdy_o, ud_rdy_o}, {exp_cs_rdy, exp_ud_rdy});
        end else begin
          chk(blk_end_o === 1'b0 && cs_rdy_o === 1'b0 && ud_rdy_o === 1'b0, "R11 R12 no pulse",
              {blk_end_o, cs_rdy_o, ud_rdy_o}, 0);
        end
      end
    end
  endtask

  // monitor / scoreboard
  logic [127:0] cur = '0;
  int           mcnt = 0;
  always @(negedge clk_i) begin
    if (mon_on) begin
      cur[mcnt] = tx_o;
      mcnt++;
      if (mcnt == 128) begin
        mcnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", cur, 0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur === e, t, cur, e);
        end
      end
    end
  end

  task automatic wr_word(input bit is_cs, input int idx, input logic [31:0] d);
    if (is_cs) begin cs_we_i = 1'b1; cs_widx_i = 3'(idx); cs_wdata_i = d; end
    else       begin ud_we_i = 1'b1; ud_widx_i = 3'(idx); ud_wdata_i = d; end
    @(negedge clk_i);
    cs_we_i = 1'b0; ud_we_i = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(tx_o === 1'b0 && smp_ready_o === 1'b0 && blk_end_o === 1'b0 && udr_o === 1'b0, "R1 reset",
        {tx_o, smp_ready_o, blk_end_o, udr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // banks written while idle are live at enable (R10)
    for (int i = 0; i < 6; i++) begin
      cs_act[i] = 32'hA5C3_0F12 + 32'(i) * 32'h1357_2468;
      ud_act[i] = 32'h3C96_E1B4 ^ (32'(i) * 32'h0F0F_1111);
      wr_word(1'b1, i, cs_act[i]);
      wr_word(1'b0, i, ud_act[i]);
    end
    repeat (3) @(negedge clk_i);
    chk(tx_o === 1'b0 && smp_ready_o === 1'b0 && cs_rdy_o === 1'b0 && ud_rdy_o === 1'b0, "R1 idle",
        {tx_o, smp_ready_o, cs_rdy_o, ud_rdy_o}, 0);

    // block 1
    tx_en_i = 1'b1;
    model_lvl = 1'b0;
    for (int f = 0; f < 192; f++) begin
      logic [23:0] l, r;
      bit have, mono;
      string tag;
      l = 24'((f * 32'h01F3A7) ^ 32'h5A5A5);
      r = ~l ^ 24'(f);
      have = !(f % 17 == 5);
      mono = (f % 7 == 3);
      tag = "R3 R5 R7 R9 frame";
      if (!have) tag = {tag, " R8"};
      if (mono)  tag = {tag, " R6"};
      if (f == 0) tag = {tag, " R1 R4"};
      pend_wr = (f == 50);
      pend_data = ~cs_act[0];
      drive_frame(f, l, r, have, mono, f[0], f[2], f[1], tag, 1'b1, 1'b0);
    end
    pend_wr = 1'b0;
    cs_act[0] = ~cs_act[0];

    // block 2: shadow word now live, preamble B again
    for (int f = 0; f < 4; f++) begin
      drive_frame(f, 24'hF00000 | 24'(f), 24'h00000F << f, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
                  f == 0 ? "R4 R10 new block" : "R10 new block", 1'b0, 1'b0);
    end
    tx_en_i = 1'b0;
    #1 mon_on = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(tx_o === 1'b0 && smp_ready_o === 1'b0 && blk_end_o === 1'b0, "R1 after disable",
        {tx_o, smp_ready_o, blk_end_o}, 0);

    // idle write, then restart at block start
    ud_act[0] = 32'hFFFF_0001;
    wr_word(1'b0, 0, ud_act[0]);
    @(negedge clk_i);
    tx_en_i = 1'b1;
    model_lvl = 1'b0;
    drive_frame(0, 24'h123456, 24'hABCDEF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R4 R10 restart", 1'b0, 1'b0);
    tx_en_i = 1'b0;
    #1 mon_on = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all frames seen", 128'(exp_q.size()), 0);
    summary();
    $finish;
  end
endmodule